// File: doc/BRIEF.md
# CPU Cluster Clock and Reset Controller

This block holds the clock-stop and reset state for up to four cores in a processor cluster. Software reaches it over a plain 32-bit register bus with a write strobe, a byte offset and write data. Read data is returned in the same cycle, decoded from the offset with no strobe.

Each core has one clock-stop bit and four reset lanes. Software can change the clock-stop bits by writing the whole control word, or through aliases that only set or only clear the bits written as 1. The reset lanes can only be changed through set and clear aliases. Reading the reset-set offset returns the current reset word. A read-only status word reports, through a two-stage synchronizer, which cores have all four lanes asserted. Software asserts reset, then polls that word until the core's bit reads 1.

Top module: `ccr_cluster_ctrl`

## Requirements
- R1: After reset, core 0 runs with its clock enabled and all four of its lanes released. Every other core has its clock stopped and all four lanes asserted. With four cores, reset word = 0xEEEE, clock word = 0x00000E00 and status = 0xE.
- R2: The clock word sits at offset 0x04C and is written as a whole. Bit 8+n is the stop bit of core n: 1 stops the clock and 0 lets it run. core_clk_en[n] is the inverse of that bit, and the word reads back what was stored.
- R3: A write to offset 0x340 asserts every reset bit written as 1 and leaves the bits written as 0 unchanged.
- R4: A write to offset 0x344 releases every reset bit written as 1 and leaves the bits written as 0 unchanged.
- R5: Core n owns reset bits n, n+4, n+8 and n+12, so the mask 0x1111 shifted left by n covers all of them. These bits drive core_rst[4n+3:4n] in lane order.
- R6: A read of offset 0x340 returns the current reset word in bits 15:0.
- R7: A write to offset 0x34C clears every clock-stop bit written as 1, which restarts those clocks. Bits written as 0 are unchanged.
- R8: A write to offset 0x348 sets every clock-stop bit written as 1, which stops those clocks. Bits written as 0 are unchanged.
- R9: Status bit n at offset 0x470 reads 1 when all four lanes of core n are asserted. A change appears in the status word exactly two clock edges after the edge that changed the reset word.
- R10: The status word is read-only. A write to 0x470 changes no reset or clock state.
- R11: Unimplemented bits read as 0 and ignore writes. Reads from undecoded offsets and from the alias offsets 0x344, 0x348 and 0x34C return 0. Writes to undecoded offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_clk_en | output | NUM_CORES | Per-core clock enable, 1 = running |
| core_rst | output | 4*NUM_CORES | Per-core reset lanes, core n at [4n+3:4n], 1 = held |

## Verification
The clock word is written in three ways: a whole-word write carrying noise in the unimplemented bits, a set-alias write and a clear-alias write. Comparing the results shows that a plain write replaces the stored bits, that each alias touches only the bits written as 1, and that the high bits are dropped. The reset aliases are driven with masks covering one full core, a single lane, and the remaining lanes of a core. These show that lanes are interleaved, that a partial assertion leaves the status bit at 0, and that the status bit changes on the second edge and not the first. Writes to the status offset, to an unused offset and to the upper reset bits must leave the readable state unchanged.

// File: rtl/ccr_pkg.sv
// Shared constants, the decoded-target type and the mask helpers for the
// cluster clock/reset controller. Assumes at most four cores per cluster.
package ccr_pkg;
    localparam int DATA_W    = 32;
    localparam int MAX_CORES = 4;
    localparam int RST_LANES = 4;
    localparam int CLK_BASE  = 8;
    localparam int RST_W     = MAX_CORES * RST_LANES;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CLK_RW,
        TGT_RST_SET,
        TGT_RST_CLR,
        TGT_CLK_SET,
        TGT_CLK_CLR,
        TGT_STATUS
    } tgt_e;

    // Reset bits owned by one core: lanes interleaved with a stride of MAX_CORES.
    function automatic logic [RST_W-1:0] core_rst_mask(input int core);
        logic [RST_W-1:0] m;
        m = '0;
        for (int k = 0; k < RST_LANES; k++) m[core + k*MAX_CORES] = 1'b1;
        return m;
    endfunction

    // All reset bits that exist for a cluster of ncores cores.
    function automatic logic [RST_W-1:0] impl_rst_mask(input int ncores);
        logic [RST_W-1:0] m;
        m = '0;
        for (int c = 0; c < ncores; c++) m = m | core_rst_mask(c);
        return m;
    endfunction
endpackage

// File: rtl/ccr_addr_decode.sv
// Address decoder: maps a byte offset to one register target.
// Assumes the offsets are distinct; an unknown offset gives TGT_NONE.
module ccr_addr_decode
    import ccr_pkg::*;
#(
    parameter int              ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] OFF_CLK     = 'h04C,
    parameter logic [ADDR_W-1:0] OFF_RST_SET = 'h340,
    parameter logic [ADDR_W-1:0] OFF_RST_CLR = 'h344,
    parameter logic [ADDR_W-1:0] OFF_CLK_SET = 'h348,
    parameter logic [ADDR_W-1:0] OFF_CLK_CLR = 'h34C,
    parameter logic [ADDR_W-1:0] OFF_STATUS  = 'h470
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt
);
    // Compare the offset against each register location.
    always_comb begin
        if      (addr == OFF_CLK)     tgt = TGT_CLK_RW;
        else if (addr == OFF_RST_SET) tgt = TGT_RST_SET;
        else if (addr == OFF_RST_CLR) tgt = TGT_RST_CLR;
        else if (addr == OFF_CLK_SET) tgt = TGT_CLK_SET;
        else if (addr == OFF_CLK_CLR) tgt = TGT_CLK_CLR;
        else if (addr == OFF_STATUS)  tgt = TGT_STATUS;
        else                          tgt = TGT_NONE;
    end
endmodule

// File: rtl/ccr_reset_bank.sv
// Reset word with write-one-to-set and write-one-to-clear updates.
// Assumes set_we and clr_we are never high together (single bus address).
// Bits of cores that are not present stay 0.
module ccr_reset_bank
    import ccr_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [RST_W-1:0] wbits,
    output logic [RST_W-1:0] rst_word
);
    localparam logic [RST_W-1:0] IMPL    = impl_rst_mask(NUM_CORES);
    localparam logic [RST_W-1:0] DEFAULT = IMPL & ~core_rst_mask(0);

    // Hold the reset lanes; the aliases only touch bits written as 1.
    always_ff @(posedge clk) begin
        if (!rst_n)      rst_word <= DEFAULT;
        else if (set_we) rst_word <= (rst_word | wbits) & IMPL;
        else if (clr_we) rst_word <= rst_word & ~wbits & IMPL;
    end
endmodule

// File: rtl/ccr_clock_bank.sv
// Per-core clock-stop bits: whole-word write plus set and clear aliases.
// Assumes at most one write enable is high in a cycle.
module ccr_clock_bank #(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 plain_we,
    input  logic                 set_we,
    input  logic                 clr_we,
    input  logic [NUM_CORES-1:0] wbits,
    output logic [NUM_CORES-1:0] stop
);
    localparam logic [NUM_CORES-1:0] STOP_DEF = {NUM_CORES{1'b1}} << 1;

    // Update the stop bits according to the addressed alias.
    always_ff @(posedge clk) begin
        if (!rst_n)        stop <= STOP_DEF;
        else if (plain_we) stop <= wbits;
        else if (set_we)   stop <= stop | wbits;
        else if (clr_we)   stop <= stop & ~wbits;
    end
endmodule

// File: rtl/ccr_status_sync.sv
// Two-flop synchronizer that carries each core's "fully in reset" flag
// into the status word. Resets to the power-on held pattern.
module ccr_status_sync #(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] held,
    output logic [NUM_CORES-1:0] status
);
    localparam logic [NUM_CORES-1:0] HELD_DEF = {NUM_CORES{1'b1}} << 1;
    logic [NUM_CORES-1:0] stage1;

    // Shift the held flags through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= HELD_DEF;
            status <= HELD_DEF;
        end else begin
            stage1 <= held;
            status <= stage1;
        end
    end
endmodule

// File: rtl/ccr_cluster_ctrl.sv
// Cluster clock/reset controller top: decodes the register bus, holds the
// reset lanes and clock-stop bits, and reports synchronized reset status.
// Assumes 1 <= NUM_CORES <= 4 and a single-address bus, so that two
// targets are never written in the same cycle.
module ccr_cluster_ctrl
    import ccr_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr_en,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NUM_CORES-1:0]      core_clk_en,
    output logic [4*NUM_CORES-1:0]    core_rst
);
    tgt_e                 tgt;
    logic [RST_W-1:0]     rst_word;
    logic [NUM_CORES-1:0] clk_stop;
    logic [NUM_CORES-1:0] held;
    logic [NUM_CORES-1:0] status_q;

    ccr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .tgt  (tgt)
    );

    ccr_reset_bank #(.NUM_CORES(NUM_CORES)) u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (bus_wr_en && tgt == TGT_RST_SET),
        .clr_we   (bus_wr_en && tgt == TGT_RST_CLR),
        .wbits    (bus_wdata[RST_W-1:0]),
        .rst_word (rst_word)
    );

    ccr_clock_bank #(.NUM_CORES(NUM_CORES)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .plain_we (bus_wr_en && tgt == TGT_CLK_RW),
        .set_we   (bus_wr_en && tgt == TGT_CLK_SET),
        .clr_we   (bus_wr_en && tgt == TGT_CLK_CLR),
        .wbits    (bus_wdata[CLK_BASE +: NUM_CORES]),
        .stop     (clk_stop)
    );

    // Per-core fan-out of reset lanes, clock enables and held flags.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        for (genvar k = 0; k < RST_LANES; k++) begin : g_lane
            assign core_rst[c*RST_LANES + k] = rst_word[c + k*MAX_CORES];
        end
        assign core_clk_en[c] = ~clk_stop[c];
        assign held[c]        = &core_rst[c*RST_LANES +: RST_LANES];
    end

    ccr_status_sync #(.NUM_CORES(NUM_CORES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .held   (held),
        .status (status_q)
    );

    // Read mux: only the plain clock word, reset word and status are readable.
    always_comb begin
        bus_rdata = '0;
        case (tgt)
            TGT_CLK_RW:  bus_rdata[CLK_BASE +: NUM_CORES] = clk_stop;
            TGT_RST_SET: bus_rdata[RST_W-1:0]             = rst_word;
            TGT_STATUS:  bus_rdata[NUM_CORES-1:0]         = status_q;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ccr_cluster_chk.sv
// Property checker for ccr_cluster_ctrl, attached by bind. Watches the bus,
// the stored state and the synchronized status.
module ccr_cluster_chk
    import ccr_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr_en,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [RST_W-1:0]       rst_word,
    input logic [NUM_CORES-1:0]   clk_stop,
    input logic [NUM_CORES-1:0]   status_q
);
    localparam logic [RST_W-1:0] IMPL = impl_rst_mask(NUM_CORES);
    logic [1:0]           age;
    logic [NUM_CORES-1:0] full;

    // Count edges since reset so two-deep history is always defined.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // Independent view of which cores have every lane asserted.
    always_comb begin
        for (int c = 0; c < NUM_CORES; c++)
            full[c] = (rst_word & core_rst_mask(c)) == core_rst_mask(c);
    end

    p_plain_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'('h04C))
        |=> clk_stop == $past(bus_wdata[CLK_BASE +: NUM_CORES]));

    p_rst_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'('h340))
        |=> (rst_word & $past(bus_wdata[RST_W-1:0]) & IMPL)
            == ($past(bus_wdata[RST_W-1:0]) & IMPL));

    p_rst_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'('h344))
        |=> (rst_word & $past(bus_wdata[RST_W-1:0])) == '0);

    p_clk_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'('h34C))
        |=> (clk_stop & $past(bus_wdata[CLK_BASE +: NUM_CORES])) == '0);

    p_clk_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'('h348))
        |=> (clk_stop & $past(bus_wdata[CLK_BASE +: NUM_CORES]))
            == $past(bus_wdata[CLK_BASE +: NUM_CORES]));

    p_status_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> status_q == $past(full, 2));

    p_status_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == ADDR_W'('h470))
        |=> $stable(rst_word) && $stable(clk_stop));

    p_rst_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'('h340)) |-> bus_rdata[DATA_W-1:RST_W] == '0);
endmodule

bind ccr_cluster_ctrl ccr_cluster_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rst_word  (rst_word),
    .clk_stop  (clk_stop),
    .status_q  (status_q)
);

// File: tb/tb_ccr_cluster_ctrl.sv
// Directed bench for ccr_cluster_ctrl: one task per scenario.
module tb_ccr_cluster_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  core_clk_en;
    logic [15:0] core_rst;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ccr_cluster_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_clk_en(core_clk_en), .core_rst(core_rst)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_defaults();
        logic [31:0] v;
        rd(12'h340, v); check("R1 reset word", v, 32'h0000EEEE);
        rd(12'h04C, v); check("R1 clock word", v, 32'h00000E00);
        rd(12'h470, v); check("R1 status", v, 32'h0000000E);
        check("R1 clk_en", {28'd0, core_clk_en}, 32'h1);
        check("R1 core_rst", {16'd0, core_rst}, 32'hFFF0);
    endtask

    task automatic t_clock_plain();
        logic [31:0] v;
        wr(12'h04C, 32'hFFFF_F5FF);
        rd(12'h04C, v); check("R2 R11 clock word masked", v, 32'h00000500);
        check("R2 clk_en", {28'd0, core_clk_en}, 32'hA);
    endtask

    task automatic t_clock_alias();
        logic [31:0] v;
        wr(12'h348, 32'h0000_0200);
        check("R8 set alias clk_en", {28'd0, core_clk_en}, 32'h8);
        wr(12'h34C, 32'h0000_0500);
        check("R7 clear alias clk_en", {28'd0, core_clk_en}, 32'hD);
        rd(12'h04C, v); check("R7 clock word", v, 32'h00000200);
        rd(12'h348, v); check("R11 alias reads zero", v, 32'h0);
    endtask

    task automatic t_reset_clear();
        logic [31:0] v;
        wr(12'h344, 32'h0000_4444);
        rd(12'h340, v); check("R4 R6 reset word", v, 32'h0000AAAA);
        check("R5 core2 lanes released", {16'd0, core_rst}, 32'hF0F0);
        repeat (2) @(negedge clk);
        rd(12'h470, v); check("R9 status after release", v, 32'hA);
    endtask

    task automatic t_reset_set();
        logic [31:0] v;
        wr(12'h340, 32'h0000_0001);
        rd(12'h340, v); check("R3 single lane", v, 32'h0000AAAB);
        check("R5 core0 lane0", {16'd0, core_rst}, 32'hF0F1);
        repeat (2) @(negedge clk);
        rd(12'h470, v); check("R9 partial lanes not held", v, 32'hA);
        wr(12'h340, 32'h0000_1110);
        rd(12'h340, v); check("R3 remaining lanes", v, 32'h0000BBBB);
        check("R5 core0 all lanes", {16'd0, core_rst}, 32'hF0FF);
        rd(12'h470, v); check("R9 no change at first negedge", v, 32'hA);
        @(negedge clk);
        rd(12'h470, v); check("R9 no change after one edge", v, 32'hA);
        @(negedge clk);
        rd(12'h470, v); check("R9 set after two edges", v, 32'hB);
    endtask

    task automatic t_status_ro();
        logic [31:0] v;
        wr(12'h470, 32'hFFFF_FFFF);
        rd(12'h340, v); check("R10 reset word kept", v, 32'h0000BBBB);
        rd(12'h04C, v); check("R10 clock word kept", v, 32'h00000200);
        repeat (3) @(negedge clk);
        rd(12'h470, v); check("R10 status kept", v, 32'hB);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, v); check("R11 undecoded read", v, 32'h0);
        rd(12'h04C, v); check("R11 clock after stray write", v, 32'h00000200);
        rd(12'h340, v); check("R11 reset after stray write", v, 32'h0000BBBB);
        wr(12'h340, 32'hFFFF_0000);
        rd(12'h340, v); check("R11 upper bits ignored", v, 32'h0000BBBB);
        rd(12'h344, v); check("R11 clear alias reads zero", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_defaults();
        t_clock_plain();
        t_clock_alias();
        t_reset_clear();
        t_reset_set();
        t_status_ro();
        t_unimpl();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule